// File: doc/BRIEF.md
# Immediate Operand Fetch Sequencer

This block fetches the immediate operand that follows an opcode, one byte at a time, over an 8-bit memory read port. The instruction decoder pulses a strobe once the opcode is decoded. With that strobe it presents the program counter, which has already been advanced to the byte after the opcode, and a 2-bit length code. The sequencer then issues the byte reads, places each returned byte in its lane of a 32-bit operand register, and reports the program counter that points past the operand.

Two operand layouts are supported, selected at the strobe. In little-endian layout the advanced program counter is driven straight onto the address bus and stepped upward. In big-endian layout the sequencer spends one cycle loading a separate access pointer with the address of the operand's last byte, which is its least significant byte. It then steps that pointer downward. In both layouts the bytes arrive least significant first, so the lane index is simply the number of bytes fetched so far, and both layouts produce the same 32-bit value.

Top module: `imm_fetch_seq`

## Requirements
- R1: After reset the block is idle: `busy`, `memRd` and `done` are low.
- R2: `lenCode` selects the operand length n: 0 means no bytes, 1 means one byte, 2 means two bytes and 3 means four bytes. A strobe is accepted only while `busy` is low.
- R3: In little-endian mode (`bigEndian` low at the strobe), `memRd` rises in the cycle after the strobe with `memAddr` equal to `pcIn`. Each later read uses the previous address plus one.
- R4: In big-endian mode, the cycle after the strobe is an address calculation cycle with `busy` high and `memRd` low. The first read follows at `pcIn`+n-1, and each later read uses the previous address minus one, ending at `pcIn`.
- R5: While `memRd` is high and `memRdy` is low, `memAddr` and `laneIdx` hold their values. A byte is taken from `memData` at each clock edge where `memRd` and `memRdy` are both high.
- R6: The k-th byte taken (k counted from 0) is written to `operand` bits 8k+7 down to 8k, and `laneIdx` shows k during that read. The result is that the byte at `pcIn`+k lands in lane k in little-endian mode, and the byte at `pcIn`+j lands in lane n-1-j in big-endian mode. Lanes not written read as zero.
- R7: `done` is high for exactly one cycle: the cycle after the last byte is taken. During that cycle `pcOut` equals `pcIn`+n (modulo the address width) and `operand` holds the complete value.
- R8: With n = 0, `done` is raised in the cycle after the strobe, no read is issued, and `pcOut` equals `pcIn`.
- R9: A strobe raised while `busy` is high is ignored: the addresses, the operand and `pcOut` of the running fetch are unchanged.
- R10: `bigEndian` is sampled only at an accepted strobe. Changing it during a fetch has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| decStrobe | input | 1 | Opcode decoded; start an operand fetch |
| lenCode | input | 2 | Immediate length code (0/1/2/4 bytes) |
| bigEndian | input | 1 | Operand layout: 1 selects big-endian |
| pcIn | input | ADDR_W | Program counter, already at opcode+1 |
| memRdy | input | 1 | Memory has the read byte on memData |
| memData | input | 8 | Read data byte |
| memAddr | output | ADDR_W | Byte address of the current read |
| memRd | output | 1 | Read request |
| laneIdx | output | 2 | Operand lane that the current read fills |
| operand | output | 32 | Assembled operand |
| pcOut | output | ADDR_W | Program counter past the operand, valid with done |
| done | output | 1 | One-cycle completion pulse |
| busy | output | 1 | A fetch is in progress |

## Verification
The assertions take for granted that `memRdy` is only meaningful while `memRd` is high. They also assume that `pcIn` and `lenCode` are valid in the cycle of an accepted strobe. The stimulus raises `memRdy` only in cycles where `memRd` is seen high, and it stretches each read by a random number of wait cycles. It holds the strobe fields steady for exactly one cycle. It also deliberately toggles `decStrobe` and `bigEndian` while a fetch runs, so that the ignore rules are exercised without breaking the handshake assumption. The random program counter values include addresses near the top of the address space, so address wrap is covered.

// File: rtl/imm_fetch_pkg.sv
package imm_fetch_pkg;
  localparam int LANES  = 4;
  localparam int LANE_W = $clog2(LANES);
  localparam int CNT_W  = LANE_W + 1;
  localparam int BYTE_W = 8;
  localparam int OPND_W = LANES * BYTE_W;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_CALC,
    ST_FETCH,
    ST_DONE
  } seq_state_t;

  typedef struct packed {
    logic start;     // latch pc and length, clear operand
    logic calcFar;   // load pointer with far byte address
    logic capture;   // take memData into current lane, step pointer
    logic stepDown;  // pointer direction for capture
  } dp_ctrl_t;

  function automatic logic [CNT_W-1:0] lenBytes(input logic [1:0] code);
    logic [CNT_W-1:0] n;
    case (code)
      2'd0:    n = CNT_W'(0);
      2'd1:    n = CNT_W'(1);
      2'd2:    n = CNT_W'(2);
      default: n = CNT_W'(4);
    endcase
    return n;
  endfunction
endpackage

// File: rtl/imm_fetch_ctrl.sv
module imm_fetch_ctrl
  import imm_fetch_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     decStrobe,
  input  logic     bigEndian,
  input  logic [1:0] lenCode,
  input  logic     memRdy,
  input  logic     lastByte,
  output dp_ctrl_t ctrl,
  output logic     memRd,
  output logic     done,
  output logic     busy,
  output logic     beMode
);
  seq_state_t state, stateNext;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      beMode <= 1'b0;
    end else begin
      state <= stateNext;
      if (state == ST_IDLE && decStrobe) beMode <= bigEndian;
    end
  end

  always_comb begin
    ctrl      = '0;
    stateNext = state;
    case (state)
      ST_IDLE: begin
        if (decStrobe) begin
          ctrl.start = 1'b1;
          if (lenCode == 2'd0)  stateNext = ST_DONE;
          else if (bigEndian)   stateNext = ST_CALC;
          else                  stateNext = ST_FETCH;
        end
      end
      ST_CALC: begin
        ctrl.calcFar = 1'b1;
        stateNext    = ST_FETCH;
      end
      ST_FETCH: begin
        if (memRdy) begin
          ctrl.capture  = 1'b1;
          ctrl.stepDown = beMode;
          if (lastByte) stateNext = ST_DONE;
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  assign memRd = (state == ST_FETCH);
  assign done  = (state == ST_DONE);
  assign busy  = (state != ST_IDLE);

  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (!memRd && !done));
endmodule

// File: rtl/imm_fetch_dp.sv
module imm_fetch_dp
  import imm_fetch_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  dp_ctrl_t          ctrl,
  input  logic [ADDR_W-1:0] pcIn,
  input  logic [1:0]        lenCode,
  input  logic [BYTE_W-1:0] memData,
  output logic [ADDR_W-1:0] ptr,
  output logic [LANE_W-1:0] lane,
  output logic              lastByte,
  output logic [ADDR_W-1:0] pcFinal,
  output logic [OPND_W-1:0] operand
);
  logic [ADDR_W-1:0] basePc;
  logic [CNT_W-1:0]  cnt;
  logic [CNT_W-1:0]  nBytes;
  logic [BYTE_W-1:0] laneReg [LANES];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      basePc <= '0;
      ptr    <= '0;
      cnt    <= '0;
      nBytes <= '0;
    end else if (ctrl.start) begin
      basePc <= pcIn;
      ptr    <= pcIn;
      cnt    <= '0;
      nBytes <= lenBytes(lenCode);
    end else if (ctrl.calcFar) begin
      ptr <= basePc + ADDR_W'(nBytes) - ADDR_W'(1);
    end else if (ctrl.capture) begin
      ptr <= ctrl.stepDown ? ptr - ADDR_W'(1) : ptr + ADDR_W'(1);
      cnt <= cnt + CNT_W'(1);
    end
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    always_ff @(posedge clk) begin
      if (!rstN || ctrl.start)
        laneReg[g] <= '0;
      else if (ctrl.capture && cnt == CNT_W'(g))
        laneReg[g] <= memData;
    end
    assign operand[g*BYTE_W +: BYTE_W] = laneReg[g];
  end

  assign lane     = cnt[LANE_W-1:0];
  assign lastByte = (cnt == nBytes - CNT_W'(1));
  assign pcFinal  = basePc + ADDR_W'(nBytes);

  // R6
  lane_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.capture |-> (cnt < nBytes));
endmodule

// File: rtl/imm_fetch_seq.sv
module imm_fetch_seq
  import imm_fetch_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              decStrobe,
  input  logic [1:0]        lenCode,
  input  logic              bigEndian,
  input  logic [ADDR_W-1:0] pcIn,
  input  logic              memRdy,
  input  logic [7:0]        memData,
  output logic [ADDR_W-1:0] memAddr,
  output logic              memRd,
  output logic [1:0]        laneIdx,
  output logic [31:0]       operand,
  output logic [ADDR_W-1:0] pcOut,
  output logic              done,
  output logic              busy
);
  dp_ctrl_t ctrl;
  logic     lastByte;
  logic     beMode;

  imm_fetch_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .decStrobe(decStrobe), .bigEndian(bigEndian),
    .lenCode(lenCode), .memRdy(memRdy), .lastByte(lastByte), .ctrl(ctrl),
    .memRd(memRd), .done(done), .busy(busy), .beMode(beMode)
  );

  imm_fetch_dp #(.ADDR_W(ADDR_W)) u_dp (
    .clk(clk), .rstN(rstN), .ctrl(ctrl), .pcIn(pcIn), .lenCode(lenCode),
    .memData(memData), .ptr(memAddr), .lane(laneIdx), .lastByte(lastByte),
    .pcFinal(pcOut), .operand(operand)
  );

  // R3
  le_first_chk: assert property (@(posedge clk) disable iff (!rstN)
    (decStrobe && !busy && !bigEndian && lenCode != 2'd0)
      |=> (memRd && memAddr == $past(pcIn)));

  // R3
  le_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (memRd && memRdy && !lastByte && !beMode)
      |=> (memRd && memAddr == $past(memAddr) + ADDR_W'(1)));

  // R4
  be_calc_chk: assert property (@(posedge clk) disable iff (!rstN)
    (decStrobe && !busy && bigEndian && lenCode != 2'd0)
      |=> (busy && !memRd));

  // R4
  be_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (memRd && memRdy && !lastByte && beMode)
      |=> (memRd && memAddr == $past(memAddr) - ADDR_W'(1)));

  // R5
  wait_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (memRd && !memRdy) |=> (memRd && $stable(memAddr) && $stable(laneIdx)));

  // R8
  zero_len_chk: assert property (@(posedge clk) disable iff (!rstN)
    (decStrobe && !busy && lenCode == 2'd0) |=> (done && pcOut == $past(pcIn)));
endmodule

// File: tb/imm_fetch_seq_tb.sv
module imm_fetch_seq_tb;
  localparam int AW = 16;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          decStrobe = 1'b0;
  logic [1:0]    lenCode = '0;
  logic          bigEndian = 1'b0;
  logic [AW-1:0] pcIn = '0;
  logic          memRdy = 1'b0;
  logic [7:0]    memData = '0;
  logic [AW-1:0] memAddr;
  logic          memRd;
  logic [1:0]    laneIdx;
  logic [31:0]   operand;
  logic [AW-1:0] pcOut;
  logic          done;
  logic          busy;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  imm_fetch_seq #(.ADDR_W(AW)) u_dut (
    .clk(clk), .rstN(rstN), .decStrobe(decStrobe), .lenCode(lenCode),
    .bigEndian(bigEndian), .pcIn(pcIn), .memRdy(memRdy), .memData(memData),
    .memAddr(memAddr), .memRd(memRd), .laneIdx(laneIdx), .operand(operand),
    .pcOut(pcOut), .done(done), .busy(busy)
  );

  function automatic logic [7:0] memByte(input logic [AW-1:0] a);
    return 8'(a * 37 + 11) ^ a[15:8];
  endfunction

  function automatic int nOf(input logic [1:0] c);
    return (c == 2'd3) ? 4 : int'(c);
  endfunction

  function automatic logic [AW-1:0] expAddr(input logic [AW-1:0] pc, input int n,
                                            input logic be, input int k);
    return be ? AW'(pc + AW'(n - 1 - k)) : AW'(pc + AW'(k));
  endfunction

  function automatic logic [31:0] expOperand(input logic [AW-1:0] pc, input int n,
                                             input logic be);
    logic [31:0] v = '0;
    for (int j = 0; j < n; j++) begin
      if (be) v[8*(n-1-j) +: 8] = memByte(AW'(pc + AW'(j)));
      else    v[8*j +: 8]       = memByte(AW'(pc + AW'(j)));
    end
    return v;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Called at a negedge; returns at the negedge after the done pulse.
  task automatic runFetch(input logic [AW-1:0] pc, input logic [1:0] code,
                          input logic be, input bit junk, input int waitPct);
    int n = nOf(code);
    int k = 0;
    int cyc = 0;
    bit seenRead = 0;
    decStrobe = 1'b1; pcIn = pc; lenCode = code; bigEndian = be;
    forever begin
      @(negedge clk);
      cyc++;
      if (junk) begin
        decStrobe = ($urandom % 2) == 0;   // R9 strobes while busy
        pcIn      = AW'($urandom);
        lenCode   = 2'($urandom);
        bigEndian = ~bigEndian;            // R10 mode toggles while busy
      end else begin
        decStrobe = 1'b0;
      end
      if (done) begin
        decStrobe = 1'b0; memRdy = 1'b0;
        check(be ? "R4 read count" : "R3 read count", k, n);
        check(n == 0 ? "R8 zero pc" : "R7 pcOut", 32'(pcOut), 32'(AW'(pc + AW'(n))));
        check(junk ? "R9/R10 operand" : "R6 operand", operand, expOperand(pc, n, be));
        if (n == 0) check("R8 done latency", cyc, 1);
        @(negedge clk);
        check("R7 done width", 32'(done), 0);
        return;
      end
      if (memRd) begin
        if (!seenRead) begin
          seenRead = 1;
          check(be ? "R4 calc cycle" : "R3 first read", cyc, be ? 2 : 1);
        end
        check(be ? "R4 address" : "R3 address", 32'(memAddr), 32'(expAddr(pc, n, be, k)));
        check("R6 lane", 32'(laneIdx), k);
        if (k >= n) check("R8 no read", 1, 0);
        if (int'($urandom % 100) >= waitPct) begin
          memRdy = 1'b1; memData = memByte(memAddr); k++;
        end else begin
          memRdy = 1'b0; memData = 8'($urandom);   // R5 wait cycle
        end
      end else begin
        memRdy = 1'b0;
      end
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h1f2e3d4c));
    repeat (3) @(negedge clk);
    check("R1 busy", 32'(busy), 0);
    check("R1 memRd", 32'(memRd), 0);
    check("R1 done", 32'(done), 0);
    rstN = 1'b1;
    @(negedge clk);
    // directed corners
    runFetch(16'h1001, 2'd3, 1'b0, 0, 0);   // R3 four bytes LE
    runFetch(16'h1001, 2'd3, 1'b1, 0, 0);   // R4 four bytes BE
    runFetch(16'h2000, 2'd0, 1'b0, 0, 0);   // R8 zero length LE
    runFetch(16'h2000, 2'd0, 1'b1, 0, 0);   // R8 zero length BE
    runFetch(16'h3000, 2'd1, 1'b1, 0, 50);  // R4 single byte BE
    runFetch(16'h4002, 2'd2, 1'b1, 0, 60);  // R5 waits BE
    runFetch(16'hFFFE, 2'd3, 1'b0, 0, 30);  // R3 address wrap
    runFetch(16'hFFFE, 2'd3, 1'b1, 0, 30);  // R4 address wrap
    runFetch(16'h5005, 2'd3, 1'b1, 1, 40);  // R9 R10 junk during BE
    runFetch(16'h6006, 2'd2, 1'b0, 1, 40);  // R9 R10 junk during LE
    // R2 random codes, modes and waits
    for (int i = 0; i < 400; i++) begin
      runFetch(AW'($urandom), 2'($urandom), 1'($urandom), 1'($urandom), int'($urandom % 70));
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule